// File: doc/BRIEF.md
# Serial Flash Read Command Generator

This block sits between a memory-read requester and a serial flash shifter. For each accepted read request it produces an ordered list of phase items: instruction bytes, address bytes, mode bytes, dummy bytes and one data item. Each item says which phase it belongs to, how many data lines the shifter drives for it (one, two or four), and the byte to shift. A 4-bit command selector picks one of a fixed set of read sequences. When the override input is high, the sequence is instead built from per-field inputs that give the instruction word, the mode word, the byte counts and the lane widths.

Several of the fixed sequences have a continuous variant. After one of these has run, a repeated request of the same type skips the instruction phase. Two exit types send the all-ones words that bring the flash back to normal command decoding. Any change of the selector or of the override input also ends continuous operation.

The block also derives the serial clock divisor from a 5-bit prescale code that has two ranges. It emits one tick per divided period and passes on the clock idle level and the capture edge choice.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset `req_ready` is 1, `ph_valid` is 0 and continuous operation is off, so the first request of any type sends its instruction.
- R2: Item kinds are coded 0 instruction, 1 address, 2 mode, 3 dummy, 4 data, and lanes are coded 0 single, 1 dual, 2 quad. Items of one request appear in non-decreasing kind order with no gap between them. `ph_last` marks the final item. While `ph_ready` is 0, an offered item holds all of its fields. `req_ready` is 0 from acceptance until the final item is taken.
- R3: Selector 0 sends instruction 0x03 with no dummy and single-lane data. Selector 1 sends 0x0B with one dummy byte and single-lane data. Selector 2 sends 0x3B with one dummy byte and dual data. Selector 3 sends 0x6B with one dummy byte and quad data. All four send single-lane address bytes.
- R4: Selectors 4/5 send 0xBB with dual address, mode and data lanes and no dummy. Selectors 6/7 send 0xEB with quad lanes and two dummy bytes. Selectors 8/9 send 0xE7 with quad lanes and one dummy byte. Selectors 10/11 send 0xE3 with quad lanes and no dummy. Each of these sends one mode byte: 0x00 for the even selector and 0x20 for the odd (continuous) one.
- R5: After a request with selector 5, 7, 9 or 11 (override low), the next request with the same selector omits the instruction item. If the selector or the override input differs at the cycle of the next request, or at any cycle in between, the next request sends its instruction again.
- R6: Selector 12 sends two single-lane 0xFF instruction items. Selector 13 sends one. Neither sends address or data items, and both end continuous operation. Selectors 14 and 15 are accepted and produce no item.
- R7: In override mode the instruction count code means 0 none, 1 low byte of the instruction word, 2 high byte then low byte, 3 none. The mode count follows the same coding with the mode word. The dummy count is 0 to 3 bytes of 0x00. Data lanes follow the lane coding, with 3 read as single. Address, mode and dummy items use the data lanes when the address-width input is 1, and single lane otherwise. Instructions are always single lane.
- R8: Every read sends three address items, most significant byte first, on the address lanes of its sequence.
- R9: The data item carries the transfer length in bytes: 4 when `four_byte` is 1, else 1.
- R10: For prescale codes 0 to 15 `sck_div` equals the code, with 0 read as 1. For codes 16 to 31 it equals 2×(code−16), with 16 read as 2. `sck_tick` pulses once every `sck_div` cycles.
- R11: `sck_idle` follows the polarity input and `sample_lead` is the inverse of the phase input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Generator idle, request taken |
| req_addr | input | 24 | Byte address of the read |
| cmd_type | input | 4 | Fixed sequence selector |
| four_byte | input | 1 | Data length 4 bytes (1) or 1 byte (0) |
| ovr_en | input | 1 | Build the sequence from override fields |
| ovr_instr | input | 16 | Override instruction word |
| ovr_instr_cnt | input | 2 | Override instruction byte count code |
| ovr_mode | input | 16 | Override mode word |
| ovr_mode_cnt | input | 2 | Override mode byte count code |
| ovr_dummy_cnt | input | 2 | Override dummy byte count |
| ovr_data_lanes | input | 2 | Override data lane code |
| ovr_addr_wide | input | 1 | Address, mode and dummy use the data lanes |
| psc_code | input | 5 | Serial clock prescale code |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Capture on trailing edge when 1 |
| ph_valid | output | 1 | Phase item offered |
| ph_ready | input | 1 | Shifter takes the item |
| ph_kind | output | 3 | Item kind code |
| ph_lanes | output | 2 | Lane code of the item |
| ph_byte | output | 8 | Byte to shift, or data length for data items |
| ph_last | output | 1 | Final item of the request |
| sck_div | output | 5 | Effective clock divisor |
| sck_tick | output | 1 | One pulse per divided period |
| sck_idle | output | 1 | Serial clock idle level |
| sample_lead | output | 1 | Capture on the leading edge |

## Verification
The case that can fall into one cycle is a change of the sequence selector together with acceptance of a new request while continuous operation is active. That cycle decides whether the instruction item is skipped. The bench runs a continuous selector, then raises the next request in the same cycle as it switches the selector to the plain twin, and a scoreboard that predicts a full instruction judges it. A repeat of the continuous selector around an exit and an override request confirm the skip and its cancellation. The scoreboard compares items while the shifter side stalls in an irregular pattern, so every kind boundary also meets a held item.

// File: rtl/flash_rd_seq.sv
module flash_rd_seq #(
  parameter int AW = 24,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    cmd_type,
  input  logic          four_byte,
  input  logic          ovr_en,
  input  logic [15:0]   ovr_instr,
  input  logic [1:0]    ovr_instr_cnt,
  input  logic [15:0]   ovr_mode,
  input  logic [1:0]    ovr_mode_cnt,
  input  logic [1:0]    ovr_dummy_cnt,
  input  logic [1:0]    ovr_data_lanes,
  input  logic          ovr_addr_wide,
  input  logic [PW-1:0] psc_code,
  input  logic          cpol,
  input  logic          cpha,
  output logic          ph_valid,
  input  logic          ph_ready,
  output logic [2:0]    ph_kind,
  output logic [1:0]    ph_lanes,
  output logic [7:0]    ph_byte,
  output logic          ph_last,
  output logic [PW-1:0] sck_div,
  output logic          sck_tick,
  output logic          sck_idle,
  output logic          sample_lead
);
  localparam int NAB  = AW / 8;
  localparam int HALF = 1 << (PW - 1);
  localparam logic [2:0] K_INS = 3'd0, K_ADR = 3'd1, K_MOD = 3'd2, K_DUM = 3'd3, K_DAT = 3'd4;

  logic          busy, cont_on, r_four, r_ndat;
  logic [3:0]    cont_ty;
  logic [2:0]    kind, idx, r_nins, r_nadr, r_nmod, r_ndum;
  logic [15:0]   r_ins, r_mod;
  logic [AW-1:0] r_addr;
  logic [1:0]    r_ladr, r_ldat;

  logic [2:0]  c_nins, c_nadr, c_nmod, c_ndum;
  logic        c_ndat;
  logic [15:0] c_ins, c_mod;
  logic [1:0]  c_ladr, c_ldat;

  wire accept    = req_valid && req_ready;
  wire cont_live = cont_on && !ovr_en && (cmd_type == cont_ty);
  wire is_cont   = !ovr_en && cmd_type[0] && cmd_type >= 4'd5 && cmd_type <= 4'd11;

  assign req_ready = !busy;
  assign ph_valid  = busy;

  always_comb begin
    c_nins = 3'd1; c_ins = 16'h0000; c_nadr = 3'(NAB); c_ladr = 2'd0;
    c_nmod = 3'd0; c_mod = 16'h0000; c_ndum = 3'd0; c_ndat = 1'b1; c_ldat = 2'd0;
    if (ovr_en) begin
      c_nins = (ovr_instr_cnt == 2'd3) ? 3'd0 : {1'b0, ovr_instr_cnt};
      c_ins  = ovr_instr;
      c_ldat = (ovr_data_lanes == 2'd3) ? 2'd0 : ovr_data_lanes;
      c_ladr = ovr_addr_wide ? c_ldat : 2'd0;
      c_nmod = (ovr_mode_cnt == 2'd3) ? 3'd0 : {1'b0, ovr_mode_cnt};
      c_mod  = ovr_mode;
      c_ndum = {1'b0, ovr_dummy_cnt};
    end else begin
      case (cmd_type)
        4'd0:        c_ins = 16'h0003;
        4'd1:        begin c_ins = 16'h000B; c_ndum = 3'd1; end
        4'd2:        begin c_ins = 16'h003B; c_ndum = 3'd1; c_ldat = 2'd1; end
        4'd3:        begin c_ins = 16'h006B; c_ndum = 3'd1; c_ldat = 2'd2; end
        4'd4, 4'd5:  begin c_ins = 16'h00BB; c_ladr = 2'd1; c_ldat = 2'd1; c_nmod = 3'd1; end
        4'd6, 4'd7:  begin c_ins = 16'h00EB; c_ladr = 2'd2; c_ldat = 2'd2; c_nmod = 3'd1; c_ndum = 3'd2; end
        4'd8, 4'd9:  begin c_ins = 16'h00E7; c_ladr = 2'd2; c_ldat = 2'd2; c_nmod = 3'd1; c_ndum = 3'd1; end
        4'd10, 4'd11: begin c_ins = 16'h00E3; c_ladr = 2'd2; c_ldat = 2'd2; c_nmod = 3'd1; end
        4'd12:       begin c_nins = 3'd2; c_ins = 16'hFFFF; c_nadr = 3'd0; c_ndat = 1'b0; end
        4'd13:       begin c_ins = 16'h00FF; c_nadr = 3'd0; c_ndat = 1'b0; end
        default:     begin c_nins = 3'd0; c_nadr = 3'd0; c_ndat = 1'b0; end
      endcase
      if (c_nmod != 3'd0) c_mod = cmd_type[0] ? 16'h0020 : 16'h0000;
      if (cont_live) c_nins = 3'd0;
    end
  end

  function automatic logic [2:0] low5(input logic [4:0] m);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 4; i >= 0; i--) if (m[i]) r = 3'(i);
    return r;
  endfunction

  wire [4:0] cmask = {c_ndat, |c_ndum, |c_nmod, |c_nadr, |c_nins};
  wire [4:0] rmask = {r_ndat, |r_ndum, |r_nmod, |r_nadr, |r_nins};
  wire [4:0] rest  = rmask & ~((5'd2 << kind) - 5'd1);

  logic [2:0] cur_cnt;
  always_comb
    case (kind)
      K_INS:   cur_cnt = r_nins;
      K_ADR:   cur_cnt = r_nadr;
      K_MOD:   cur_cnt = r_nmod;
      K_DUM:   cur_cnt = r_ndum;
      default: cur_cnt = 3'd1;
    endcase

  wire       end_kind = (idx == cur_cnt - 3'd1);
  wire [2:0] sh       = cur_cnt - 3'd1 - idx;

  assign ph_kind = kind;
  assign ph_last = end_kind && (rest == 5'd0);

  always_comb
    case (kind)
      K_INS:   ph_byte = 8'(r_ins >> {sh, 3'b000});
      K_ADR:   ph_byte = 8'(r_addr >> {sh, 3'b000});
      K_MOD:   ph_byte = 8'(r_mod >> {sh, 3'b000});
      K_DAT:   ph_byte = r_four ? 8'd4 : 8'd1;
      default: ph_byte = 8'h00;
    endcase

  assign ph_lanes = (kind == K_INS) ? 2'd0 : (kind == K_DAT) ? r_ldat : r_ladr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; kind <= K_INS; idx <= 3'd0; cont_on <= 1'b0; cont_ty <= 4'd0;
      r_nins <= 3'd0; r_nadr <= 3'd0; r_nmod <= 3'd0; r_ndum <= 3'd0; r_ndat <= 1'b0;
      r_ins <= 16'h0; r_mod <= 16'h0; r_addr <= '0; r_ladr <= 2'd0; r_ldat <= 2'd0; r_four <= 1'b0;
    end else begin
      if (accept) begin
        busy <= |cmask; kind <= low5(cmask); idx <= 3'd0;
        r_nins <= c_nins; r_nadr <= c_nadr; r_nmod <= c_nmod; r_ndum <= c_ndum; r_ndat <= c_ndat;
        r_ins <= c_ins; r_mod <= c_mod; r_addr <= req_addr; r_ladr <= c_ladr; r_ldat <= c_ldat;
        r_four <= four_byte;
      end else if (ph_valid && ph_ready) begin
        if (!end_kind) idx <= idx + 3'd1;
        else if (rest == 5'd0) busy <= 1'b0;
        else begin kind <= low5(rest); idx <= 3'd0; end
      end
      if (accept && is_cont) begin cont_on <= 1'b1; cont_ty <= cmd_type; end
      else if (!cont_live) cont_on <= 1'b0;
    end

  logic [PW-1:0] pcnt;
  always_comb
    if (psc_code < PW'(HALF)) sck_div = (psc_code == '0) ? PW'(1) : psc_code;
    else sck_div = (psc_code == PW'(HALF)) ? PW'(2) : (psc_code - PW'(HALF)) << 1;

  assign sck_tick    = pcnt >= sck_div - PW'(1);
  assign sck_idle    = cpol;
  assign sample_lead = !cpha;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else pcnt <= sck_tick ? '0 : pcnt + PW'(1);

  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid && !ph_ready |=> ph_valid && $stable(ph_byte) && $stable(ph_kind) && $stable(ph_lanes) && $stable(ph_last));
  a_r2_kind_order: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid && ph_ready && !ph_last |=> ph_valid && ph_kind >= $past(ph_kind));
  a_r2_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid && ph_ready && ph_last |=> !ph_valid && req_ready);
  a_r9_data_len: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid && ph_kind == K_DAT |-> ph_byte == 8'd1 || ph_byte == 8'd4);
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick && sck_div > PW'(1) |=> !sck_tick || sck_div != $past(sck_div));
endmodule

// File: tb/flash_rd_seq_tb_top.sv
module flash_rd_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [23:0] req_addr = '0;
  logic [3:0] cmd_type = '0;
  logic four_byte = 0, ovr_en = 0, ovr_addr_wide = 0;
  logic [15:0] ovr_instr = '0, ovr_mode = '0;
  logic [1:0] ovr_instr_cnt = '0, ovr_mode_cnt = '0, ovr_dummy_cnt = '0, ovr_data_lanes = '0;
  logic [4:0] psc_code = '0;
  logic cpol = 0, cpha = 0;
  logic ph_valid, ph_ready = 0, ph_last;
  logic [2:0] ph_kind;
  logic [1:0] ph_lanes;
  logic [7:0] ph_byte;
  logic [4:0] sck_div;
  logic sck_tick, sck_idle, sample_lead;

  flash_rd_seq dut_i (.clk, .rst_n, .req_valid, .req_ready, .req_addr, .cmd_type, .four_byte,
    .ovr_en, .ovr_instr, .ovr_instr_cnt, .ovr_mode, .ovr_mode_cnt, .ovr_dummy_cnt,
    .ovr_data_lanes, .ovr_addr_wide, .psc_code, .cpol, .cpha, .ph_valid, .ph_ready,
    .ph_kind, .ph_lanes, .ph_byte, .ph_last, .sck_div, .sck_tick, .sck_idle, .sample_lead);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [13:0] exp_q[$];
  string tag_q[$];
  logic [12:0] bld[$];
  bit b_cont_on = 0;
  logic [3:0] b_cont_ty = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // stall pattern on the shifter side
  int cyc = 0;
  always begin
    @(posedge clk); #1;
    cyc++;
    ph_ready = (cyc % 5 != 3) && (cyc % 7 != 0);
  end

  // monitor: pop and compare
  logic [13:0] held;
  bit was_stall = 0;
  always @(negedge clk) begin
    logic [13:0] got;
    got = {ph_kind, ph_lanes, ph_byte, ph_last};
    if (rst_n) begin
      if (was_stall) check(ph_valid && got == held, "R2 stalled item held", 32'(got), 32'(held));
      was_stall = ph_valid && !ph_ready;
      held = got;
      if (ph_valid && ph_ready) begin
        if (exp_q.size() == 0) check(0, "R2/R6 unexpected item", 32'(got), 32'h0);
        else begin
          logic [13:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, 32'(got), 32'(e));
        end
      end
    end
  end

  task automatic add(input logic [2:0] k, input logic [1:0] ln, input logic [7:0] b);
    bld.push_back({k, ln, b});
  endtask

  // expected item list from the requirements (R3..R9)
  task automatic model(input string tag);
    int nins = 1, nad = 3, nm = 0, nd = 0, ndat = 1;
    logic [15:0] ins = 16'h0, md = 16'h0;
    logic [1:0] la = 2'd0, ld = 2'd0;
    bit live;
    live = b_cont_on && !ovr_en && cmd_type == b_cont_ty;
    if (ovr_en) begin
      nins = (ovr_instr_cnt == 2'd3) ? 0 : int'(ovr_instr_cnt);
      ins = ovr_instr; md = ovr_mode;
      ld = (ovr_data_lanes == 2'd3) ? 2'd0 : ovr_data_lanes;
      la = ovr_addr_wide ? ld : 2'd0;
      nm = (ovr_mode_cnt == 2'd3) ? 0 : int'(ovr_mode_cnt);
      nd = int'(ovr_dummy_cnt);
    end else begin
      case (cmd_type)
        4'd0: ins = 16'h03;
        4'd1: begin ins = 16'h0B; nd = 1; end
        4'd2: begin ins = 16'h3B; nd = 1; ld = 2'd1; end
        4'd3: begin ins = 16'h6B; nd = 1; ld = 2'd2; end
        4'd4, 4'd5: begin ins = 16'hBB; la = 2'd1; ld = 2'd1; nm = 1; end
        4'd6, 4'd7: begin ins = 16'hEB; la = 2'd2; ld = 2'd2; nm = 1; nd = 2; end
        4'd8, 4'd9: begin ins = 16'hE7; la = 2'd2; ld = 2'd2; nm = 1; nd = 1; end
        4'd10, 4'd11: begin ins = 16'hE3; la = 2'd2; ld = 2'd2; nm = 1; end
        4'd12: begin nins = 2; ins = 16'hFFFF; nad = 0; ndat = 0; end
        4'd13: begin ins = 16'hFF; nad = 0; ndat = 0; end
        default: begin nins = 0; nad = 0; ndat = 0; end
      endcase
      md = cmd_type[0] ? 16'h0020 : 16'h0000;
      if (live) nins = 0;
    end
    if (!ovr_en && cmd_type[0] && cmd_type >= 4'd5 && cmd_type <= 4'd11) begin
      b_cont_on = 1; b_cont_ty = cmd_type;
    end else if (!live) b_cont_on = 0;
    bld.delete();
    if (nins == 2) add(3'd0, 2'd0, ins[15:8]);
    if (nins >= 1) add(3'd0, 2'd0, ins[7:0]);
    if (nad == 3) begin
      add(3'd1, la, req_addr[23:16]); add(3'd1, la, req_addr[15:8]); add(3'd1, la, req_addr[7:0]);
    end
    if (nm == 2) add(3'd2, la, md[15:8]);
    if (nm >= 1) add(3'd2, la, md[7:0]);
    for (int i = 0; i < nd; i++) add(3'd3, la, 8'h00);
    if (ndat == 1) add(3'd4, ld, four_byte ? 8'd4 : 8'd1);
    for (int i = 0; i < bld.size(); i++) begin
      exp_q.push_back({bld[i], i == bld.size() - 1});
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
  endtask

  task automatic run_req(input logic [3:0] ty, input logic ov, input logic [23:0] a, input string tag);
    wait_idle();
    cmd_type = ty; ovr_en = ov; req_addr = a;
    model(tag);
    req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic meas(input logic [4:0] code, input int expd);
    int gap;
    @(negedge clk); psc_code = code;
    repeat (40) @(negedge clk);
    check(32'(sck_div) == 32'(expd), "R10 divisor", 32'(sck_div), 32'(expd));
    while (!sck_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sck_tick);
    check(gap == expd, "R10 tick period", 32'(gap), 32'(expd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    check(ph_valid == 1'b0, "R1 no item in reset", 32'(ph_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !ph_valid, "R1 idle after release", 32'({req_ready, ph_valid}), 32'h2);

    // R1/R5: first continuous request still sends its instruction
    run_req(4'd5, 0, 24'h123456, "R1 first continuous sends instr");
    run_req(4'd5, 0, 24'h000010, "R5 continuous skips instr");
    // selector changes in the same cycle as the request
    run_req(4'd4, 0, 24'hABCDEF, "R5 switch same cycle full instr");
    run_req(4'd4, 0, 24'h010203, "R4 dual io plain");

    // R3/R8/R9 plain reads
    four_byte = 0; run_req(4'd0, 0, 24'hA1B2C3, "R3 read 0x03");
    four_byte = 1; run_req(4'd1, 0, 24'h00FF00, "R3 fast read");
    run_req(4'd2, 0, 24'h7F8081, "R3 dual out");
    four_byte = 0; run_req(4'd3, 0, 24'hFEDCBA, "R3 quad out");
    run_req(4'd6, 0, 24'h111111, "R4 quad io plain");
    run_req(4'd8, 0, 24'h222222, "R4 word read plain");
    four_byte = 1; run_req(4'd10, 0, 24'h333333, "R4 octal word plain");

    // R5/R6 continuous with exits
    run_req(4'd7, 0, 24'h400000, "R4 quad io continuous");
    run_req(4'd7, 0, 24'h400020, "R5 quad io skip");
    run_req(4'd13, 0, 24'h0, "R6 exit quad");
    run_req(4'd7, 0, 24'h400040, "R6 after exit full instr");
    run_req(4'd7, 0, 24'h400060, "R5 skip again");
    run_req(4'd12, 0, 24'h0, "R6 exit dual");
    run_req(4'd9, 0, 24'h500000, "R4 word read continuous");
    run_req(4'd9, 0, 24'h500004, "R5 word read skip");
    run_req(4'd11, 0, 24'h600000, "R4 octal continuous");
    run_req(4'd11, 0, 24'h600010, "R5 octal skip");

    // R7 override; also ends continuous (R5)
    ovr_instr = 16'hA55A; ovr_instr_cnt = 2'd2; ovr_mode = 16'hC3E1; ovr_mode_cnt = 2'd2;
    ovr_dummy_cnt = 2'd3; ovr_data_lanes = 2'd2; ovr_addr_wide = 1;
    run_req(4'd11, 1, 24'h0A0B0C, "R7 override two instr, two mode");
    run_req(4'd11, 0, 24'h600020, "R5 override cancels continuous");
    wait_idle();
    ovr_instr_cnt = 2'd1; ovr_mode_cnt = 2'd1; ovr_dummy_cnt = 2'd0; ovr_data_lanes = 2'd1; ovr_addr_wide = 0;
    four_byte = 0;
    run_req(4'd0, 1, 24'h9ABCDE, "R7 override low byte, narrow addr");
    wait_idle();
    ovr_instr_cnt = 2'd0; ovr_mode_cnt = 2'd3; ovr_dummy_cnt = 2'd1; ovr_data_lanes = 2'd3; ovr_addr_wide = 1;
    run_req(4'd0, 1, 24'h102030, "R7 override no instr, lane code 3");
    wait_idle();
    ovr_instr_cnt = 2'd3; ovr_mode_cnt = 2'd0; ovr_dummy_cnt = 2'd2; ovr_data_lanes = 2'd1; ovr_addr_wide = 1;
    run_req(4'd0, 1, 24'h405060, "R7 override instr code 3");

    // R6 unused selectors: no effect at the ports
    run_req(4'd14, 0, 24'h1, "R6 unused 14");
    repeat (6) @(negedge clk);
    check(!ph_valid && req_ready, "R6 selector 14 no item", 32'({ph_valid, req_ready}), 32'h1);
    run_req(4'd15, 0, 24'h2, "R6 unused 15");
    repeat (6) @(negedge clk);
    check(!ph_valid && req_ready, "R6 selector 15 no item", 32'({ph_valid, req_ready}), 32'h1);
    wait_idle();

    // R10 prescaler
    meas(5'd0, 1); meas(5'd1, 1); meas(5'd3, 3); meas(5'd15, 15);
    meas(5'd16, 2); meas(5'd17, 2); meas(5'd19, 6); meas(5'd31, 30);

    // R11 clock mode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); cpol = m[1]; cpha = m[0];
      @(negedge clk);
      check(sck_idle == cpol && sample_lead == !cpha, "R11 clock mode",
            32'({sck_idle, sample_lead}), 32'({cpol, !cpha}));
    end

    wait_idle();
    check(exp_q.size() == 0, "R2 all expected items seen", 32'(exp_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule